// File: doc/BRIEF.md
# Transmit Bit-Error Insertion Unit

This unit sits in a bit-serial transmit path and corrupts chosen bits of the outgoing stream on purpose, so that a far-end receiver's error detection can be tested. Each bit travels with a valid strobe. The unit passes every valid bit through with one clock of delay and inverts it when an error is due.

Errors come from two sources, and they can be active at the same time. The first source is periodic: a 3-bit rate field `n` makes one bit in every 10^n valid bits inverted. The second source is single errors on demand. Each single error is triggered by the rising edge of either a configuration bit or an external manual-request pin. A mode bit picks which of the two is used, and an enable bit gates all single errors.

All control fields are loaded together by a one-cycle write strobe. A rate written while periodic insertion is running does not take effect at once: it is held back until the next error has been inserted at the old rate.

Top module: `txErrInsert`

## Requirements
- R1: Each bit presented with `bitValid`=1 appears on `bitOut` one clock later, with `outValid`=1 in that cycle. `outValid` is 0 after any cycle without a valid bit, and in such cycles `bitOut` holds its value. After reset, `bitOut` and `outValid` are 0. With no error due, `bitOut` equals the input bit.
- R2: When the rate field `n` (1 to 7) is written while periodic insertion is idle, the valid bits accepted after the write cycle are counted from 1. Every bit whose count is a multiple of 10^n is inverted. Cycles without a valid bit do not advance the count.
- R3: A rate of 0 written while idle starts no periodic insertion, and no bit is inverted by the periodic source.
- R4: A rate written while periodic insertion runs (0 included) is applied only at the next error inserted at the old rate. Counting restarts from that error, so with old rate 2 rewritten to 1 the errors fall at counts 100, 110, 120 and so on.
- R5: While the single-error enable is 0, a rising edge of the selected request source inserts no error.
- R6: In mode 0 with single errors enabled, a 0-to-1 change of the request config bit inverts exactly one bit: the first valid bit accepted at least two cycles after the write. Writing 1 over an existing 1 inserts nothing.
- R7: Several rising edges of the request source with no valid bit between them give exactly one error.
- R8: In mode 1, single errors come from the manual-request pin after a two-stage synchronizer, so a pin rise is usable three cycles later. The request config bit is then ignored.
- R9: Switching the mode to a source that is already 1 counts as a rising edge and inserts one error.
- R10: A bit that is hit by both a periodic and a single error is inverted once, not restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | Marks `bitIn` as a bit of the stream this cycle |
| bitOut | output | 1 | Serial data bit, possibly inverted, one cycle later |
| outValid | output | 1 | Marks `bitOut` as valid |
| cfgWe | input | 1 | Loads all control fields this cycle |
| cfgRate | input | 3 | Periodic rate exponent n (0 = off) |
| cfgSingleEn | input | 1 | Enable for single-error insertion |
| cfgSingleReq | input | 1 | Single-error request bit (mode 0) |
| cfgPinMode | input | 1 | 0: request from config bit, 1: from pin |
| manualReq | input | 1 | Asynchronous manual single-error request |

## Verification
Periodic insertion is run at exponents 1, 2 and 3, with random gaps in the valid strobe. This separates counting of valid bits from counting of clocks. A rate rewrite in mid-period, and a rewrite to zero, show whether the rate change is deferred or applied at once. Single requests are driven as a single rise, as a repeated 1, as a burst of rises with no valid bit between them, from the pin, from the config bit while the pin is selected, and by a mode switch onto a high source. Each of these cases tells edge detection apart from level detection and shows whether the chosen source is the one that acts. A single request placed on the same bit as a periodic error shows whether the two errors cancel. Short random rate runs then cover further lengths.

// File: rtl/txErrPkg.sv
package txErrPkg;
  typedef struct packed {
    logic periodicHit;
    logic singleHit;
  } errStrobes_t;

  function automatic longint pow10(input int unsigned e);
    longint r = 1;
    for (int unsigned i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/errRatePacer.sv
module errRatePacer #(
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              bitValid,
  output logic              hit
);
  import txErrPkg::*;
  localparam int unsigned MAX_EXP = (1 << RATE_W) - 1;
  localparam int unsigned CNT_W   = $clog2(pow10(MAX_EXP) + 1);

  logic [RATE_W-1:0] activeRate, pendingRate, nextRate;
  logic [CNT_W-1:0]  cnt, lastCount;
  logic              running, wrap;

  assign running   = (activeRate != '0);
  assign lastCount = CNT_W'(pow10(int'(activeRate)) - 1);
  assign wrap      = running && bitValid && (cnt == lastCount);
  assign nextRate  = cfgWe ? cfgRate : pendingRate;
  assign hit       = wrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeRate  <= '0;
      pendingRate <= '0;
      cnt         <= '0;
    end else begin
      if (cfgWe) pendingRate <= cfgRate;
      if (!running) begin
        if (cfgWe) begin
          activeRate <= cfgRate;
          cnt        <= '0;
        end
      end else if (bitValid) begin
        if (wrap) begin
          cnt        <= '0;
          activeRate <= nextRate;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/singleErrReq.sv
module singleErrReq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic singleEn,
  input  logic regReq,
  input  logic pinMode,
  input  logic manualReq,
  input  logic bitValid,
  output logic hit
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic src, prevSrc, rise, pending;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= manualReq;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign src  = pinMode ? syncChain[SYNC_STAGES-1] : regReq;
  assign rise = src && !prevSrc;
  assign hit  = bitValid && pending && singleEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSrc <= 1'b0;
      pending <= 1'b0;
    end else begin
      prevSrc <= src;
      if (!singleEn) pending <= 1'b0;
      else           pending <= (pending && !bitValid) || rise;
    end
  end
endmodule

// File: rtl/errCtrl.sv
module errCtrl #(
  parameter int unsigned RATE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitValid,
  input  logic                   cfgWe,
  input  logic [RATE_W-1:0]      cfgRate,
  input  logic                   cfgSingleEn,
  input  logic                   cfgSingleReq,
  input  logic                   cfgPinMode,
  input  logic                   manualReq,
  output txErrPkg::errStrobes_t  strobes
);
  logic singleEnReg, reqReg, pinModeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      singleEnReg <= 1'b0;
      reqReg      <= 1'b0;
      pinModeReg  <= 1'b0;
    end else if (cfgWe) begin
      singleEnReg <= cfgSingleEn;
      reqReg      <= cfgSingleReq;
      pinModeReg  <= cfgPinMode;
    end
  end

  errRatePacer #(.RATE_W(RATE_W)) u_pacer (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRate(cfgRate),
    .bitValid(bitValid), .hit(strobes.periodicHit)
  );

  singleErrReq #(.SYNC_STAGES(SYNC_STAGES)) u_single (
    .clk(clk), .rstN(rstN), .singleEn(singleEnReg), .regReq(reqReg),
    .pinMode(pinModeReg), .manualReq(manualReq), .bitValid(bitValid),
    .hit(strobes.singleHit)
  );
endmodule

// File: rtl/errDatapath.sv
module errDatapath (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitIn,
  input  logic                  bitValid,
  input  txErrPkg::errStrobes_t strobes,
  output logic                  bitOut,
  output logic                  outValid
);
  logic flip;
  assign flip = strobes.periodicHit || strobes.singleHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitOut   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= bitValid;
      if (bitValid) bitOut <= bitIn ^ flip;
    end
  end
endmodule

// File: rtl/txErrInsert.sv
module txErrInsert #(
  parameter int unsigned RATE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  output logic              bitOut,
  output logic              outValid,
  input  logic              cfgWe,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              cfgSingleEn,
  input  logic              cfgSingleReq,
  input  logic              cfgPinMode,
  input  logic              manualReq
);
  txErrPkg::errStrobes_t hitStrobes;

  errCtrl #(.RATE_W(RATE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .cfgWe(cfgWe),
    .cfgRate(cfgRate), .cfgSingleEn(cfgSingleEn), .cfgSingleReq(cfgSingleReq),
    .cfgPinMode(cfgPinMode), .manualReq(manualReq), .strobes(hitStrobes)
  );

  errDatapath u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .strobes(hitStrobes), .bitOut(bitOut), .outValid(outValid)
  );
endmodule

// File: rtl/txErrInsertChecker.sv
module txErrInsertChecker (
  input logic                  clk,
  input logic                  rstN,
  input logic                  bitIn,
  input logic                  bitValid,
  input logic                  bitOut,
  input logic                  outValid,
  input txErrPkg::errStrobes_t hitStrobes
);
  // R1: a valid bit is followed by a valid output
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> outValid);

  // R1: no valid bit means no valid output and a held data bit
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> (!outValid && $stable(bitOut)));

  // R1: a bit with no error due passes through unchanged
  a_r1_clean_pass: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !hitStrobes.periodicHit && !hitStrobes.singleHit)
      |=> (bitOut == $past(bitIn)));

  // R10: any hit, including both at once, inverts the bit exactly once
  a_r10_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && (hitStrobes.periodicHit || hitStrobes.singleHit))
      |=> (bitOut != $past(bitIn)));
endmodule

bind txErrInsert txErrInsertChecker u_chk (
  .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
  .bitOut(bitOut), .outValid(outValid), .hitStrobes(hitStrobes)
);

// File: tb/txErrInsert_bench.sv
`timescale 1ns/1ps
module txErrInsert_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0;
  logic bitOut, outValid;
  logic cfgWe = 1'b0;
  logic [2:0] cfgRate = '0;
  logic cfgSingleEn = 1'b0, cfgSingleReq = 1'b0, cfgPinMode = 1'b0;
  logic manualReq = 1'b0;

  int total = 0;
  int bad = 0;
  int outCount = 0;
  int base = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit sentQ[$];
  int flips[$];

  always #2.5 clk = ~clk;

  txErrInsert u_txErrInsert (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .bitOut(bitOut), .outValid(outValid), .cfgWe(cfgWe), .cfgRate(cfgRate),
    .cfgSingleEn(cfgSingleEn), .cfgSingleReq(cfgSingleReq),
    .cfgPinMode(cfgPinMode), .manualReq(manualReq)
  );

  // Monitor: compare each output bit with the bit sent, log inversions
  always @(negedge clk) begin
    if (rstN && outValid) begin
      bit sent;
      sent = (sentQ.size() > 0) ? sentQ.pop_front() : 1'b0;
      outCount++;
      if (bitOut != sent) flips.push_back(outCount - base);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bitValid = 1'b0; cfgWe = 1'b0; manualReq = 1'b0;
    cfgRate = '0; cfgSingleEn = 1'b0; cfgSingleReq = 1'b0; cfgPinMode = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
    sentQ.delete(); flips.delete(); outCount = 0; base = 0;
  endtask

  task automatic writeCfg(input logic [2:0] rate, input logic en,
                          input logic req, input logic mode);
    @(negedge clk);
    cfgWe = 1'b1; cfgRate = rate; cfgSingleEn = en;
    cfgSingleReq = req; cfgPinMode = mode;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic markStart();
    flips.delete();
    base = outCount;
  endtask

  task automatic sendBits(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        bitValid = 1'b0;
      end
      @(negedge clk);
      bitValid = 1'b1;
      bitIn = 1'($urandom);
      sentQ.push_back(bitIn);
    end
    @(negedge clk);
    bitValid = 1'b0;
    waitCycles(2);
  endtask

  // Expected inversion positions for period p over n bits, limited to count
  function automatic void periodicExp(input int p, input int n, input int startAt,
                                      input int stopAfter, ref int q[$]);
    q.delete();
    for (int k = startAt; k <= n; k += p) begin
      if (stopAfter > 0 && q.size() >= stopAfter) break;
      q.push_back(k);
    end
  endfunction

  function automatic int pow10i(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  task automatic checkFlips(input string tag, input int expQ[$]);
    bit same;
    total++;
    same = (flips.size() == expQ.size());
    if (same) foreach (expQ[i]) if (flips[i] != expQ[i]) same = 1'b0;
    if (!same) begin
      bad++;
      $display("FAIL %s: actual=%p expected=%p", tag, flips, expQ);
    end
  endtask

  initial begin
    int expQ[$];
    void'($urandom(32'h5eed_1234));
    doReset();

    // R1 reset state
    total++;
    if (bitOut !== 1'b0 || outValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b%b expected=00", bitOut, outValid);
    end

    // R1 pass-through with gaps, no error source configured
    markStart(); sendBits(40, 1'b1);
    expQ.delete(); checkFlips("R1 passthrough", expQ);
    total++;
    if (outCount != 40) begin
      bad++;
      $display("FAIL R1 count: actual=%0d expected=40", outCount);
    end

    // R2 periodic at rates 1, 2, 3 with valid gaps
    for (int r = 1; r <= 3; r++) begin
      int p, n;
      doReset();
      p = pow10i(r);
      n = 2 * p + p / 2;
      writeCfg(3'(r), 1'b0, 1'b0, 1'b0);
      markStart(); sendBits(n, 1'b1);
      periodicExp(p, n, p, 0, expQ);
      checkFlips("R2 periodic", expQ);
    end

    // R3 rate zero
    doReset();
    writeCfg(3'd0, 1'b0, 1'b0, 1'b0);
    markStart(); sendBits(150, 1'b1);
    expQ.delete(); checkFlips("R3 rate zero", expQ);

    // R4 rewrite to zero is deferred to the next error
    doReset();
    writeCfg(3'd1, 1'b0, 1'b0, 1'b0);
    markStart(); sendBits(5, 1'b0);
    writeCfg(3'd0, 1'b0, 1'b0, 1'b0);
    sendBits(40, 1'b1);
    expQ = '{10}; checkFlips("R4 stop deferred", expQ);

    // R4 rate change from 2 to 1 mid-period
    doReset();
    writeCfg(3'd2, 1'b0, 1'b0, 1'b0);
    markStart(); sendBits(30, 1'b1);
    writeCfg(3'd1, 1'b0, 1'b0, 1'b0);
    sendBits(100, 1'b1);
    expQ = '{100, 110, 120, 130}; checkFlips("R4 rate change", expQ);

    // R6 register rising edge, repeated 1, fresh edge
    doReset();
    writeCfg(3'd0, 1'b1, 1'b1, 1'b0);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ = '{1}; checkFlips("R6 reg edge", expQ);
    writeCfg(3'd0, 1'b1, 1'b1, 1'b0);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ.delete(); checkFlips("R6 level ignored", expQ);
    writeCfg(3'd0, 1'b1, 1'b0, 1'b0);
    writeCfg(3'd0, 1'b1, 1'b1, 1'b0);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ = '{1}; checkFlips("R6 second edge", expQ);

    // R5 disabled
    doReset();
    writeCfg(3'd0, 1'b0, 1'b1, 1'b0);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ.delete(); checkFlips("R5 disabled", expQ);

    // R7 multiple edges between opportunities
    doReset();
    writeCfg(3'd0, 1'b1, 1'b1, 1'b0);
    writeCfg(3'd0, 1'b1, 1'b0, 1'b0);
    writeCfg(3'd0, 1'b1, 1'b1, 1'b0);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ = '{1}; checkFlips("R7 collapse", expQ);

    // R8 pin mode
    doReset();
    writeCfg(3'd0, 1'b1, 1'b0, 1'b1);
    @(negedge clk); manualReq = 1'b1;
    waitCycles(6);
    markStart(); sendBits(10, 1'b1);
    expQ = '{1}; checkFlips("R8 pin edge", expQ);
    writeCfg(3'd0, 1'b1, 1'b1, 1'b1);
    waitCycles(3);
    markStart(); sendBits(10, 1'b1);
    expQ.delete(); checkFlips("R8 reg ignored", expQ);
    @(negedge clk); manualReq = 1'b0;
    waitCycles(6);
    @(negedge clk); manualReq = 1'b1;
    waitCycles(6);
    markStart(); sendBits(10, 1'b1);
    expQ = '{1}; checkFlips("R8 pin second edge", expQ);

    // R9 mode switch onto a high source
    doReset();
    writeCfg(3'd0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); manualReq = 1'b1;
    waitCycles(6);
    markStart(); sendBits(5, 1'b1);
    expQ.delete(); checkFlips("R9 pin unselected", expQ);
    writeCfg(3'd0, 1'b1, 1'b0, 1'b1);
    waitCycles(3);
    markStart(); sendBits(5, 1'b1);
    expQ = '{1}; checkFlips("R9 mode switch", expQ);

    // R10 periodic and single error on the same bit
    doReset();
    writeCfg(3'd1, 1'b1, 1'b0, 1'b0);
    markStart(); sendBits(9, 1'b0);
    writeCfg(3'd1, 1'b1, 1'b1, 1'b0);
    waitCycles(3);
    sendBits(11, 1'b0);
    expQ = '{10, 20}; checkFlips("R10 coincide", expQ);

    // R2 random lengths and rates
    for (int it = 0; it < 4; it++) begin
      int r, n;
      doReset();
      r = 1 + int'($urandom % 2);
      n = 20 + int'($urandom % 300);
      writeCfg(3'(r), 1'b0, 1'b0, 1'b0);
      markStart(); sendBits(n, 1'b1);
      periodicExp(pow10i(r), n, pow10i(r), 0, expQ);
      checkFlips("R2 random", expQ);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule